// File: doc/BRIEF.md
# NAND Two-Plane Program Sequencer

This block runs the host side of a two-plane program on a NAND target. After a start request it drives the command, address and data byte bus to load the first plane and then queues that plane with an intermediate confirm. It polls status until the short busy ends, loads the second plane, and closes the operation with one final command. In page mode that command is a page program. In cache mode it is a cache program. Both planes receive the same block and page, and only the plane-select address bit differs between them.

Data bytes arrive on a valid/ready stream. While a plane is taking data, the host may ask the sequencer to move the column pointer; the sequencer then inserts a random-data-input command followed by a new column. After the final command the sequencer waits for the target to be ready and reads the fail bit that belongs to the chosen mode. When that bit is set, it asks each plane separately through the enhanced status command and reports a fail flag for each plane. A counter limits how long any busy wait may last.

Top module: `tpp_seq`

## Requirements
- R1: A start is accepted in idle only when both plane operation kinds are program (kind 0). Any other start raises `rej_o` for one cycle, leaves `busy_o` low and writes nothing on the bus.
- R2: Each plane load is written as command 80h (CLE), then five ALE bytes, then exactly DATA_N data bytes taken from `din_i` in arrival order. The address bytes are column low, column high, row byte 0, row byte 1 and row byte 2.
- R3: The row word is block × 2^(PG_W+1) + plane × 2^PG_W + page, so the plane-select bit is bit 6 of row byte 0 with default widths. It is 0 for the first load and 1 for the second, and block and page are identical in both loads.
- R4: The first load uses column `col0_i` and the second uses `col1_i`. Column bytes are zero-extended.
- R5: When `jmp_i` is high during data input, no data byte is taken that cycle. The sequencer writes 85h followed by the two bytes of `jmp_col_i`, and the byte count of the plane is unchanged.
- R6: The first load is closed with 11h and followed directly by 70h. Status is then read until bit 6 is 1, and the next bus write is the 80h of the second load.
- R7: The second load is closed with 10h in page mode (`cache_i` = 0) and 15h in cache mode.
- R8: After the final command, page mode waits for status bits 6 and 5 both set. Cache mode waits for bit 6 only.
- R9: The fail bit is status bit 0 in page mode and bit 1 in cache mode. When that bit is clear at ready, the run ends with `fail_o` = 00 and no 78h is written.
- R10: When that bit is set, the sequencer writes 78h and three row bytes for plane 0, reads status, then does the same for plane 1. `fail_o[p]` takes the mode's fail bit from the read for plane p.
- R11: If `tmo_lim_i` (at least 1) status reads within one wait all show bit 6 clear, the run ends with `tmo_o` = 1 and the bus goes quiet.
- R12: `busy_o` is high from the cycle after an accepted start until the run ends. `done_o` is a single-cycle pulse while `busy_o` is low.
- R13: CLE and ALE are never high together, and a read strobe never coincides with a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request |
| cache_i | input | 1 | 0: final page program, 1: final cache program |
| kind_a_i | input | 1 | Operation kind for plane 0 (0 program, 1 other) |
| kind_b_i | input | 1 | Operation kind for plane 1 (0 program, 1 other) |
| blk_i | input | BLK_W | Block address |
| page_i | input | PG_W | Page address |
| col0_i | input | COL_W | Start column, plane 0 |
| col1_i | input | COL_W | Start column, plane 1 |
| tmo_lim_i | input | TMO_W | Busy-read limit per wait |
| din_i | input | 8 | Data byte |
| din_valid_i | input | 1 | Data byte valid |
| din_ready_o | output | 1 | Data byte taken this cycle when valid |
| jmp_i | input | 1 | Column jump request |
| jmp_col_i | input | COL_W | Column for the jump |
| sts_i | input | 8 | Status byte, sampled while `ren_o` is high |
| cle_o | output | 1 | Bus byte is a command |
| ale_o | output | 1 | Bus byte is an address |
| wen_o | output | 1 | Write strobe |
| ren_o | output | 1 | Status read strobe |
| dq_o | output | 8 | Bus byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Run finished (one cycle) |
| fail_o | output | 2 | Per-plane program failure |
| tmo_o | output | 1 | Run ended on busy timeout |
| rej_o | output | 1 | Start rejected (one cycle) |

## Verification
The bench builds the sequencer with DATA_N = 6 and TMO_W = 8 and leaves the address widths at their defaults. Six data bytes per plane let the bench place a column jump before the first byte, in the middle of a load and before the last byte, all within a few dozen cycles. An 8-bit limit makes a timeout after five busy reads short to reach. The bench's target model keeps bit 5 low for a long time after bit 6 returns, which separates the page-mode and cache-mode ready rules.

// File: rtl/tpp_pkg.sv
package tpp_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_C80, S_ADR, S_DAT, S_J85, S_JAD,
    S_CLS, S_S70, S_SRD, S_E78, S_EAD, S_ERD
  } tpp_state_t;

  localparam logic [7:0] OP_LOAD  = 8'h80;
  localparam logic [7:0] OP_JUMP  = 8'h85;
  localparam logic [7:0] OP_QUEUE = 8'h11;
  localparam logic [7:0] OP_PAGE  = 8'h10;
  localparam logic [7:0] OP_CACHE = 8'h15;
  localparam logic [7:0] OP_STAT  = 8'h70;
  localparam logic [7:0] OP_ESTAT = 8'h78;

  localparam int SB_RDY = 6;
  localparam int SB_ARR = 5;
  localparam int SB_F1  = 1;
  localparam int SB_F0  = 0;

  // byte k of a 40-bit column/row word, k = 0 is the least significant
  function automatic logic [7:0] pick_byte(input logic [39:0] w, input logic [2:0] k);
    logic [39:0] s;
    s = w >> {k, 3'b000};
    return s[7:0];
  endfunction

  // readiness rule: queue wait and cache finish need bit 6; page finish needs 6 and 5
  function automatic logic ready_ok(input logic [7:0] s, input logic fin, input logic cache);
    if (!fin || cache) return s[SB_RDY];
    return s[SB_RDY] & s[SB_ARR];
  endfunction

  function automatic logic fail_bit(input logic [7:0] s, input logic cache);
    return cache ? s[SB_F1] : s[SB_F0];
  endfunction

  function automatic logic [7:0] close_code(input logic second, input logic cache);
    if (!second) return OP_QUEUE;
    return cache ? OP_CACHE : OP_PAGE;
  endfunction

endpackage

// File: rtl/tpp_addr.sv
module tpp_addr #(
  parameter int COL_W = 12,
  parameter int PG_W  = 6,
  parameter int BLK_W = 10
) (
  input  logic [COL_W-1:0] col_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [PG_W-1:0]  pg_i,
  input  logic             plane_i,
  input  logic [2:0]       idx_i,
  output logic [7:0]       byte_o
);
  localparam int ROW_W = BLK_W + 1 + PG_W;

  logic [ROW_W-1:0] row;
  logic [39:0]      word;

  assign row    = {blk_i, plane_i, pg_i};
  assign word   = {24'(row), 16'(col_i)};
  assign byte_o = tpp_pkg::pick_byte(word, idx_i);
endmodule

// File: rtl/tpp_wait.sv
module tpp_wait #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [TMO_W-1:0] lim_i,
  output logic             expire_o
);
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clear_i) cnt <= '0;
    else if (tick_i)  cnt <= cnt + 1'b1;
  end

  assign expire_o = tick_i && (TMO_W'(cnt + 1'b1) == lim_i);
endmodule

// File: rtl/tpp_seq.sv
module tpp_seq #(
  parameter int COL_W  = 12,
  parameter int PG_W   = 6,
  parameter int BLK_W  = 10,
  parameter int DATA_N = 2112,
  parameter int TMO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cache_i,
  input  logic             kind_a_i,
  input  logic             kind_b_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [PG_W-1:0]  page_i,
  input  logic [COL_W-1:0] col0_i,
  input  logic [COL_W-1:0] col1_i,
  input  logic [TMO_W-1:0] tmo_lim_i,
  input  logic [7:0]       din_i,
  input  logic             din_valid_i,
  output logic             din_ready_o,
  input  logic             jmp_i,
  input  logic [COL_W-1:0] jmp_col_i,
  input  logic [7:0]       sts_i,
  output logic             cle_o,
  output logic             ale_o,
  output logic             wen_o,
  output logic             ren_o,
  output logic [7:0]       dq_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       fail_o,
  output logic             tmo_o,
  output logic             rej_o
);
  import tpp_pkg::*;

  localparam int DCNT_W = $clog2(DATA_N + 1);
  localparam logic [DCNT_W-1:0] LAST_BYTE = DCNT_W'(DATA_N - 1);

  tpp_state_t        st;
  logic              plane, eplane, final_ph, cache_q;
  logic [2:0]        idx;
  logic [DCNT_W-1:0] dcnt;
  logic [COL_W-1:0]  c0_q, c1_q, jcol_q;
  logic [BLK_W-1:0]  blk_q;
  logic [PG_W-1:0]   pg_q;
  logic [1:0]        fail_q;
  logic              tmo_q, done_q, rej_q;

  // named events, observed by the checker
  logic accept_w, reject_w, data_take_w, jump_take_w;
  logic rd_ready_w, rd_fail_w, expire_w;

  logic [COL_W-1:0] col_mux;
  logic [2:0]       idx_mux;
  logic             plane_mux;
  logic [7:0]       abyte;

  assign accept_w    = (st == S_IDLE) && start_i && !kind_a_i && !kind_b_i;
  assign reject_w    = (st == S_IDLE) && start_i && (kind_a_i || kind_b_i);
  assign din_ready_o = (st == S_DAT) && !jmp_i;
  assign data_take_w = din_ready_o && din_valid_i;
  assign jump_take_w = (st == S_DAT) && jmp_i;
  assign rd_ready_w  = (st == S_SRD) && ready_ok(sts_i, final_ph, cache_q);
  assign rd_fail_w   = fail_bit(sts_i, cache_q);

  assign col_mux   = (st == S_JAD) ? jcol_q : (plane ? c1_q : c0_q);
  assign idx_mux   = (st == S_EAD) ? idx + 3'd2 : idx;
  assign plane_mux = (st == S_EAD) ? eplane : plane;

  tpp_addr #(.COL_W(COL_W), .PG_W(PG_W), .BLK_W(BLK_W)) u_addr (
    .col_i  (col_mux),
    .blk_i  (blk_q),
    .pg_i   (pg_q),
    .plane_i(plane_mux),
    .idx_i  (idx_mux),
    .byte_o (abyte)
  );

  tpp_wait #(.TMO_W(TMO_W)) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (st == S_S70),
    .tick_i  ((st == S_SRD) && !rd_ready_w),
    .lim_i   (tmo_lim_i),
    .expire_o(expire_w)
  );

  // bus drive, decoded from the current state
  always_comb begin
    cle_o = 1'b0;
    ale_o = 1'b0;
    wen_o = 1'b0;
    ren_o = 1'b0;
    dq_o  = 8'h00;
    unique case (st)
      S_C80: begin cle_o = 1'b1; wen_o = 1'b1; dq_o = OP_LOAD;  end
      S_J85: begin cle_o = 1'b1; wen_o = 1'b1; dq_o = OP_JUMP;  end
      S_S70: begin cle_o = 1'b1; wen_o = 1'b1; dq_o = OP_STAT;  end
      S_E78: begin cle_o = 1'b1; wen_o = 1'b1; dq_o = OP_ESTAT; end
      S_CLS: begin cle_o = 1'b1; wen_o = 1'b1; dq_o = close_code(plane, cache_q); end
      S_ADR, S_JAD, S_EAD: begin ale_o = 1'b1; wen_o = 1'b1; dq_o = abyte; end
      S_DAT: if (data_take_w) begin wen_o = 1'b1; dq_o = din_i; end
      S_SRD, S_ERD: ren_o = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      plane    <= 1'b0;
      eplane   <= 1'b0;
      final_ph <= 1'b0;
      cache_q  <= 1'b0;
      idx      <= '0;
      dcnt     <= '0;
      c0_q     <= '0;
      c1_q     <= '0;
      jcol_q   <= '0;
      blk_q    <= '0;
      pg_q     <= '0;
      fail_q   <= '0;
      tmo_q    <= 1'b0;
      done_q   <= 1'b0;
      rej_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rej_q  <= reject_w;
      unique case (st)
        S_IDLE: if (accept_w) begin
          st       <= S_C80;
          plane    <= 1'b0;
          final_ph <= 1'b0;
          cache_q  <= cache_i;
          c0_q     <= col0_i;
          c1_q     <= col1_i;
          blk_q    <= blk_i;
          pg_q     <= page_i;
          fail_q   <= '0;
          tmo_q    <= 1'b0;
        end
        S_C80: begin st <= S_ADR; idx <= '0; end
        S_ADR: begin
          if (idx == 3'd4) begin st <= S_DAT; dcnt <= '0; end
          else idx <= idx + 3'd1;
        end
        S_DAT: begin
          if (jump_take_w) begin
            st     <= S_J85;
            jcol_q <= jmp_col_i;
          end else if (data_take_w) begin
            if (dcnt == LAST_BYTE) st <= S_CLS;
            else dcnt <= dcnt + 1'b1;
          end
        end
        S_J85: begin st <= S_JAD; idx <= '0; end
        S_JAD: begin
          if (idx == 3'd1) st <= S_DAT;
          else idx <= idx + 3'd1;
        end
        S_CLS: begin st <= S_S70; final_ph <= plane; end
        S_S70: st <= S_SRD;
        S_SRD: begin
          if (rd_ready_w) begin
            if (!final_ph) begin
              st    <= S_C80;
              plane <= 1'b1;
            end else if (rd_fail_w) begin
              st     <= S_E78;
              eplane <= 1'b0;
            end else begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end
          end else if (expire_w) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            tmo_q  <= 1'b1;
          end
        end
        S_E78: begin st <= S_EAD; idx <= '0; end
        S_EAD: begin
          if (idx == 3'd2) st <= S_ERD;
          else idx <= idx + 3'd1;
        end
        S_ERD: begin
          fail_q[eplane] <= rd_fail_w;
          if (!eplane) begin
            eplane <= 1'b1;
            st     <= S_E78;
          end else begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (st != S_IDLE);
  assign done_o = done_q;
  assign fail_o = fail_q;
  assign tmo_o  = tmo_q;
  assign rej_o  = rej_q;
endmodule

// File: rtl/tpp_seq_chk.sv
module tpp_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cle,
  input logic       ale,
  input logic       wen,
  input logic       ren,
  input logic [7:0] dq,
  input logic       busy,
  input logic       done,
  input logic       tmo,
  input logic       rej,
  input logic       rd_ready,
  input logic       final_ph
);
  assert_cle_ale_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  assert_read_write_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(ren && wen));

  assert_load_then_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && cle && dq == 8'h80) |=> (wen && ale));

  assert_jump_then_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && cle && dq == 8'h85) |=> (wen && ale));

  assert_queue_then_poll_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && cle && dq == 8'h11) |=> (wen && cle && dq == 8'h70));

  assert_ready_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ren && rd_ready && !final_ph) |=> (wen && cle && dq == 8'h80));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_reject_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rej |-> (!busy && !wen));

  assert_timeout_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo) |-> done);
endmodule

bind tpp_seq tpp_seq_chk i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cle     (cle_o),
  .ale     (ale_o),
  .wen     (wen_o),
  .ren     (ren_o),
  .dq      (dq_o),
  .busy    (busy_o),
  .done    (done_o),
  .tmo     (tmo_o),
  .rej     (rej_o),
  .rd_ready(rd_ready_w),
  .final_ph(final_ph)
);

// File: tb/test_tpp_seq.sv
`timescale 1ns/1ps
module test_tpp_seq;
  localparam int COL_W = 12, PG_W = 6, BLK_W = 10, DATA_N = 6, TMO_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, cache_i = 0, kind_a_i = 0, kind_b_i = 0;
  logic [BLK_W-1:0] blk_i = '0;
  logic [PG_W-1:0]  page_i = '0;
  logic [COL_W-1:0] col0_i = '0, col1_i = '0, jmp_col_i = '0;
  logic [TMO_W-1:0] tmo_lim_i = 8'd40;
  logic [7:0] din_i = '0, sts_i = '0;
  logic din_valid_i = 0, jmp_i = 0;
  logic din_ready_o, cle_o, ale_o, wen_o, ren_o, busy_o, done_o, tmo_o, rej_o;
  logic [7:0] dq_o;
  logic [1:0] fail_o;

  int checks = 0, errors = 0, cyc = 0;
  logic [9:0] expq[$];

  tpp_seq #(.COL_W(COL_W), .PG_W(PG_W), .BLK_W(BLK_W), .DATA_N(DATA_N), .TMO_W(TMO_W)) i_tpp_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cache_i(cache_i),
    .kind_a_i(kind_a_i), .kind_b_i(kind_b_i), .blk_i(blk_i), .page_i(page_i),
    .col0_i(col0_i), .col1_i(col1_i), .tmo_lim_i(tmo_lim_i), .din_i(din_i),
    .din_valid_i(din_valid_i), .din_ready_o(din_ready_o), .jmp_i(jmp_i),
    .jmp_col_i(jmp_col_i), .sts_i(sts_i), .cle_o(cle_o), .ale_o(ale_o),
    .wen_o(wen_o), .ren_o(ren_o), .dq_o(dq_o), .busy_o(busy_o), .done_o(done_o),
    .fail_o(fail_o), .tmo_o(tmo_o), .rej_o(rej_o));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  function automatic int rowv(input int blk, input int pg, input int pl);
    return blk * 128 + pl * 64 + pg;
  endfunction

  task automatic push(input bit c, input bit a, input int b);
    expq.push_back({c, a, 8'(b)});
  endtask

  // expected bus writes from the requirements (R2..R7, R10)
  task automatic build(input bit cache, input int blk, input int pg, input int c0, input int c1,
                       input int ja0, input int jc0, input int ja1, input int jc1,
                       input bit [1:0] fm, input bit to, input int base);
    expq.delete();
    for (int p = 0; p < 2; p++) begin
      int col = (p == 0) ? c0 : c1;
      int r = rowv(blk, pg, p);
      int ja = (p == 0) ? ja0 : ja1;
      int jc = (p == 0) ? jc0 : jc1;
      push(1, 0, 8'h80);
      push(0, 1, col % 256); push(0, 1, col / 256);
      push(0, 1, r % 256); push(0, 1, (r / 256) % 256); push(0, 1, r / 65536);
      for (int k = 0; k < DATA_N; k++) begin
        if (k == ja) begin push(1, 0, 8'h85); push(0, 1, jc % 256); push(0, 1, jc / 256); end
        push(0, 0, (base + p * DATA_N + k) % 256);
      end
      push(1, 0, (p == 0) ? 8'h11 : (cache ? 8'h15 : 8'h10));
      push(1, 0, 8'h70);
      if (to) return;
    end
    if (fm != 0)
      for (int e = 0; e < 2; e++) begin
        int r = rowv(blk, pg, e);
        push(1, 0, 8'h78);
        push(0, 1, r % 256); push(0, 1, (r / 256) % 256); push(0, 1, r / 65536);
      end
  endtask

  task automatic run(input string tag, input bit cache, input int blk, input int pg, input int c0,
                     input int c1, input int ja0, input int jc0, input int ja1, input int jc1,
                     input bit [1:0] fm, input int dbsy, input int prog, input int arr,
                     input int lim, input bit exp_to, input int base);
    int busy = 0, abusy = 0, fin = 0, pl = 0, kp = 0, kg = 0, steps = 0, busy_reads = 0;
    int ale_n = 0;
    bit ep = 0;
    bit [1:0] jdone = 0;
    logic [7:0] lastcmd = 8'h00, last_sts = 8'h00;
    int ja[2], jc[2];
    ja[0] = ja0; ja[1] = ja1; jc[0] = jc0; jc[1] = jc1;
    build(cache, blk, pg, c0, c1, ja0, jc0, ja1, jc1, fm, exp_to, base);
    @(negedge clk);
    start_i = 1; cache_i = cache; kind_a_i = 0; kind_b_i = 0;
    blk_i = BLK_W'(blk); page_i = PG_W'(pg); col0_i = COL_W'(c0); col1_i = COL_W'(c1);
    tmo_lim_i = TMO_W'(lim);
    forever begin
      @(negedge clk);
      start_i = 0;
      steps++;
      // target model
      if (busy > 0) busy--;
      if (abusy > 0) abusy--;
      sts_i = 8'h00;
      sts_i[6] = (busy == 0);
      sts_i[5] = (busy == 0) && (abusy == 0);
      if (busy == 0 && fin != 0) begin
        bit fb = (lastcmd == 8'h78) ? fm[ep] : (fm != 0);
        if (fin == 1) sts_i[0] = fb; else sts_i[1] = fb;
      end
      // host stream
      din_valid_i = (steps % 3) != 2;
      din_i = 8'((base + kg) % 256);
      jmp_i = !jdone[pl] && (kp == ja[pl]);
      jmp_col_i = COL_W'(jc[pl]);
      #1;
      if (steps == 1) chk(busy_o == 1'b1, "R12", {tag, " busy after start"}, busy_o, 1);
      if (wen_o) begin
        logic [9:0] got = {cle_o, ale_o, dq_o};
        if (expq.size() == 0) chk(0, "R2", {tag, " extra bus write"}, got, 0);
        else begin
          logic [9:0] e = expq.pop_front();
          // R2 R3 R4 R5 R6 R7 R10: byte order and content
          chk(got == e, "R2/R3/R4/R5/R6/R7/R10", {tag, " bus write"}, got, e);
        end
        if (cle_o) begin
          lastcmd = dq_o; ale_n = 0;
          if (dq_o == 8'h11) begin busy = dbsy; abusy = 0; pl = 1; kp = 0; fin = 0; end
          if (dq_o == 8'h10 || dq_o == 8'h15) begin
            busy = prog; abusy = prog + arr; fin = (dq_o == 8'h10) ? 1 : 2;
          end
          if (dq_o == 8'h85) jdone[pl] = 1;
        end
        if (ale_o) begin
          if (lastcmd == 8'h78 && ale_n == 0) ep = dq_o[6];
          ale_n++;
        end
      end
      if (din_valid_i && din_ready_o) begin kp++; kg++; end
      if (ren_o) begin
        last_sts = sts_i;
        if (!sts_i[6]) busy_reads++;
      end
      if (done_o) break;
      if (steps > 4000) begin
        chk(0, "R12", {tag, " run did not finish"}, steps, 0);
        return;
      end
    end
    chk(expq.size() == 0, "R2", {tag, " writes outstanding"}, expq.size(), 0);
    chk(busy_o == 1'b0, "R12", {tag, " idle at done"}, busy_o, 0);
    chk(tmo_o == exp_to, "R11", {tag, " timeout flag"}, tmo_o, exp_to);
    chk(fail_o == (exp_to ? 2'b00 : fm), "R9/R10", {tag, " fail flags"}, fail_o, exp_to ? 0 : fm);
    if (exp_to) chk(busy_reads == lim, "R11", {tag, " busy reads"}, busy_reads, lim);
    else if (!cache && fm == 0) chk(last_sts[5] == 1'b1, "R8", {tag, " page waits bit 5"}, last_sts[5], 1);
    else if (cache && arr > 100) chk(abusy > 0, "R8", {tag, " cache ignores bit 5"}, abusy, 1);
    @(negedge clk);
    #1;
    chk(done_o == 1'b0, "R12", {tag, " done one cycle"}, done_o, 0);
    chk(wen_o == 1'b0 && ren_o == 1'b0, "R11", {tag, " bus quiet"}, {wen_o, ren_o}, 0);
  endtask

  task automatic try_reject(input bit ka, input bit kb);
    @(negedge clk);
    start_i = 1; kind_a_i = ka; kind_b_i = kb;
    @(negedge clk);
    start_i = 0; kind_a_i = 0; kind_b_i = 0;
    #1;
    chk(rej_o == 1'b1, "R1", "reject flag", rej_o, 1);
    chk(busy_o == 1'b0 && wen_o == 1'b0, "R1", "no activity on reject", {busy_o, wen_o}, 0);
    @(negedge clk);
    #1;
    chk(rej_o == 1'b0 && busy_o == 1'b0, "R1", "reject clears", {rej_o, busy_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk({busy_o, done_o, wen_o, ren_o, cle_o, ale_o, din_ready_o, tmo_o, rej_o} == 0 && fail_o == 0,
        "R12", "reset state", {busy_o, done_o, wen_o, ren_o}, 0);
    try_reject(0, 1);   // R1 mismatched kinds
    try_reject(1, 1);   // R1 no program at all
    // R2 R3 R4 R5 R6 R7 R8 R9: page mode, jump mid-load in plane 0, bit 5 lags bit 6
    run("page_pass", 0, 'h2A5, 'h15, 'h123, 'h7FE, 3, 'h040, 99, 0, 2'b00, 4, 6, 5, 40, 0, 8'h10);
    // R5 R7 R8: cache mode, jump before the first byte of plane 1, long array busy
    run("cache_pass", 1, 'h3FF, 'h3F, 0, 'h840, 99, 0, 0, 'h801, 2'b00, 2, 3, 1000, 40, 0, 8'h90);
    // R10: page mode, plane 1 fails, jump before last byte
    run("page_fail", 0, 1, 0, 'h010, 'h020, 5, 'h3AB, 99, 0, 2'b10, 3, 5, 0, 40, 0, 8'h33);
    // R10: cache mode, plane 0 fails
    run("cache_fail", 1, 'h155, 'h2A, 'h0FF, 'h100, 99, 0, 2, 'h005, 2'b01, 1, 4, 0, 40, 0, 8'hC0);
    // R10: both planes fail
    run("both_fail", 0, 'h200, 'h01, 'h001, 'h002, 99, 0, 99, 0, 2'b11, 2, 2, 0, 40, 0, 8'h55);
    // R11: queue busy never ends
    run("timeout", 0, 'h0AA, 'h05, 'h004, 'h008, 99, 0, 99, 0, 2'b00, 10000, 2, 0, 5, 1, 8'h70);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule